// File: doc/BRIEF.md
# Length-Selectable Single-Error-Correcting Word Encoder

This block computes 8 check bits for a 128-bit memory word. It uses a single-error-correcting shortened BCH code over GF(2^8), with 136 code positions. The parity does not always cover the whole word. A 2-bit select chooses how much of the word is covered, and the covered part is always the high-order end: the top 32, 64, 96 or all 128 bits. Every data position below the chosen segment is treated as zero when the parity is computed. Those low-order bits are still stored raw beside the check bits, but they have no error protection. The parity network is the same fixed network for every length, because the correction strength does not depend on the length.

Words enter through a valid/ready port. The select is captured together with each word. The result appears on a registered valid/ready output one cycle after the word is accepted. While `out_ready` is low, the output word stays frozen and no new input is accepted. A word is accepted in any cycle where `out_valid` is low or `out_ready` is high. This means that a drain and a new accept can happen on the same clock edge.

Top module: `vlen_sec_encoder`

## Requirements
- R1: While `rst_n` is low, and immediately after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: A word accepted on an edge where `in_valid` and `in_ready` are both 1 appears with `out_valid`=1 directly after that edge (one cycle of latency).
- R3: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data` and `out_parity` hold their values.
- R4: `in_ready` is 0 only while an output word is waiting with `out_ready`=0.
- R5: `out_data` equals the accepted 128-bit input word with every bit unchanged, including the unprotected bits.
- R6: `out_parity` is the XOR of alpha^(k+8) over every protected data bit k that is set. Alpha is a root of x^8+x^4+x^3+x^2+1, the field elements are written as 8-bit polynomial coefficient vectors, and the check bits occupy code positions 0..7. An all-zero protected segment gives parity 0.
- R7: The select encoding is 0=top 32 bits (127:96), 1=top 64 bits (127:64), 2=top 96 bits (127:32), 3=all 128 bits.
- R8: Data bits below the protected segment have no effect on `out_parity`.
- R9: The select is sampled only when a word is accepted. Changing `in_len` while a word is held at the output does not alter that word's parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Encoder can take a word |
| in_data | input | 128 | Data word |
| in_len | input | 2 | Protected-length select |
| out_valid | output | 1 | Encoded word present |
| out_ready | input | 1 | Downstream can take the word |
| out_data | output | 128 | Raw data word |
| out_parity | output | 8 | Check bits for the protected segment |

## Verification
The checker verifies the stream rules on every cycle: one-cycle latency, frozen output under back-pressure, `in_ready` dropping only while a word is blocked, and the data word passing through unchanged. The parity value itself, the mapping from select to segment, the insensitivity to unprotected bits, and the sampling of the select at acceptance can only be shown by the bench's scenarios. The bench compares each result against an independently computed field sum over random words and lengths, and it adds directed cases for single low-order bits, all-ones words, and select changes during a stall.

// File: rtl/vlen_sec_pkg.sv
package vlen_sec_pkg;
  localparam int DATA_W  = 128;
  localparam int PAR_W   = 8;
  localparam int SEG_W   = 32;
  localparam int NSEG    = DATA_W / SEG_W;
  localparam int LEN_W   = $clog2(NSEG);
  localparam logic [PAR_W-1:0] POLY_LOW = 8'h1D; // x^4+x^3+x^2+1

  typedef struct packed {
    logic [PAR_W-1:0]  parity;
    logic [DATA_W-1:0] data;
  } enc_word_t;

  // alpha^n in GF(2^8) by repeated multiply-by-x with reduction
  function automatic logic [PAR_W-1:0] alpha_pow(input int n);
    logic [PAR_W-1:0] v;
    v = 8'h01;
    for (int i = 0; i < n; i++)
      v = {v[PAR_W-2:0], 1'b0} ^ (v[PAR_W-1] ? POLY_LOW : 8'h00);
    return v;
  endfunction
endpackage

// File: rtl/vlen_sec_mask.sv
module vlen_sec_mask
  import vlen_sec_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [DATA_W-1:0] masked_o
);
  // segment s is protected when it lies within the top (len+1) segments
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic keep;
    assign keep = (int'(len_i) + s) >= (NSEG - 1);
    assign masked_o[s*SEG_W +: SEG_W] = keep ? data_i[s*SEG_W +: SEG_W] : '0;
  end
endmodule

// File: rtl/vlen_sec_parity.sv
module vlen_sec_parity
  import vlen_sec_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [PAR_W-1:0]  parity_o
);
  logic [PAR_W-1:0] term [DATA_W];

  // data bit k sits at code position k + PAR_W
  for (genvar k = 0; k < DATA_W; k++) begin : g_term
    localparam logic [PAR_W-1:0] COEF = alpha_pow(k + PAR_W);
    assign term[k] = data_i[k] ? COEF : '0;
  end

  always_comb begin
    parity_o = '0;
    for (int k = 0; k < DATA_W; k++) parity_o ^= term[k];
  end
endmodule

// File: rtl/vlen_sec_stage.sv
module vlen_sec_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_word,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_word
);
  logic load;
  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (load) out_word <= in_word;
  end
endmodule

// File: rtl/vlen_sec_encoder.sv
module vlen_sec_encoder
  import vlen_sec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [LEN_W-1:0]  in_len,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [PAR_W-1:0]  out_parity
);
  localparam int WORD_W = $bits(enc_word_t);

  logic [DATA_W-1:0] masked;
  logic [PAR_W-1:0]  par_c;
  enc_word_t         nxt, cur;

  vlen_sec_mask u_mask (.data_i(in_data), .len_i(in_len), .masked_o(masked));
  vlen_sec_parity u_par (.data_i(masked), .parity_o(par_c));

  assign nxt.parity = par_c;
  assign nxt.data   = in_data;

  vlen_sec_stage #(.W(WORD_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(nxt),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(cur)
  );

  assign out_data   = cur.data;
  assign out_parity = cur.parity;
endmodule

// File: rtl/vlen_sec_encoder_chk.sv
module vlen_sec_encoder_chk
  import vlen_sec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [PAR_W-1:0]  out_parity
);
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_parity)));

  p_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready));

  p_passthru_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_data == $past(in_data)));
endmodule

bind vlen_sec_encoder vlen_sec_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_parity(out_parity)
);

// File: tb/vlen_sec_encoder_test.sv
module vlen_sec_encoder_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic [1:0]   in_len = 2'd0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;
  logic [7:0]   out_parity;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  vlen_sec_encoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_len(in_len), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_parity(out_parity)
  );

  // reference: x^n mod (x^8+x^4+x^3+x^2+1)
  function automatic logic [7:0] ref_pow(input int n);
    logic [8:0] v = 9'h001;
    for (int i = 0; i < n; i++) begin
      v = v << 1;
      if (v[8]) v = v ^ 9'h11D;
    end
    return v[7:0];
  endfunction

  function automatic logic [7:0] ref_par(input logic [127:0] d, input logic [1:0] l);
    logic [7:0] p = '0;
    int lo = 128 - 32 * (int'(l) + 1);
    for (int k = lo; k < 128; k++) if (d[k]) p ^= ref_pow(k + 8);
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [135:0] act, input logic [135:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive word, wait for accept; returns at the negedge after the accept edge
  task automatic send(input logic [127:0] d, input logic [1:0] l);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_len = l;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_out(input logic [127:0] d, input logic [1:0] l, input string req);
    chk(out_valid == 1'b1, "R2", {135'd0, out_valid}, 136'd1);
    chk(out_data == d, "R5", {8'd0, out_data}, {8'd0, d});
    chk(out_parity == ref_par(d, l), req, {128'd0, out_parity}, {128'd0, ref_par(d, l)});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] a, b;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1", {134'd0, out_valid, in_ready}, 136'd1);
    rst_n = 1'b1;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1", {134'd0, out_valid, in_ready}, 136'd1);

    // R6: all-zero protected segment and single top bit
    send('0, 2'd3);
    expect_out('0, 2'd3, "R6");
    send({1'b1, 127'd0}, 2'd0);
    expect_out({1'b1, 127'd0}, 2'd0, "R6");
    chk(out_parity == ref_pow(135), "R6", {128'd0, out_parity}, {128'd0, ref_pow(135)});

    // R8: bit below the protected segment does not change parity
    send(128'h1 << 95, 2'd0);
    chk(out_parity == 8'h00, "R8", {128'd0, out_parity}, 136'd0);
    send(128'h1 << 31, 2'd2);
    chk(out_parity == 8'h00, "R8", {128'd0, out_parity}, 136'd0);
    send(128'h1 << 32, 2'd2);
    chk(out_parity == ref_pow(40), "R7", {128'd0, out_parity}, {128'd0, ref_pow(40)});

    // R7: all ones under every select
    for (int l = 0; l < 4; l++) begin
      send('1, 2'(l));
      expect_out('1, 2'(l), "R7");
    end

    // R3/R4/R9: back-pressure with select changed while held
    @(negedge clk);
    out_ready = 1'b0;
    a = {$urandom, $urandom, $urandom, $urandom};
    b = {$urandom, $urandom, $urandom, $urandom};
    send(a, 2'd1);
    in_valid = 1'b1; in_data = b; in_len = 2'd2;
    chk(in_ready == 1'b0, "R4", {135'd0, in_ready}, 136'd0);
    repeat (3) @(negedge clk);
    in_len = 2'd3;
    @(negedge clk);
    chk(out_data == a && out_valid, "R3", {8'd0, out_data}, {8'd0, a});
    chk(out_parity == ref_par(a, 2'd1), "R9", {128'd0, out_parity}, {128'd0, ref_par(a, 2'd1)});
    in_len = 2'd2;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    in_len = 2'd0;
    expect_out(b, 2'd2, "R9");
    @(negedge clk);
    chk(out_valid == 1'b0, "R2", {135'd0, out_valid}, 136'd0);

    // random words and lengths
    for (int i = 0; i < 300; i++) begin
      logic [127:0] d;
      logic [1:0] l;
      d = {$urandom, $urandom, $urandom, $urandom};
      l = 2'($urandom_range(0, 3));
      send(d, l);
      expect_out(d, l, "R6");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule